// File: doc/BRIEF.md
# Quad Double-Buffered Converter Register Interface

This block is the digital register core in front of four 12-bit voltage-output converters. A host reaches it over a shared parallel bus. The bus has a bidirectional 12-bit data path, a 2-bit channel select, a read/write strobe, an active-low chip select, an active-low load and an active-low clear. Each channel holds two ranks of registers. The first rank, the staging register, is written and read back over the bus. The second rank, the output register, drives the code presented to the analog converter. A code D stands for the fraction D/4096 of the reference span, in straight binary with bit 11 as the MSB.

The block is modelled synchronously to a system clock, and every control pin is sampled at the rising edge. The host can stage new values on all four channels and then move them all to the outputs in one cycle by pulling load low while chip select is high. This gives glitch-free simultaneous updates. A host can also hold load low during a write, so that the new value reaches the selected output at once. Clear overrides every other control, ignores chip select, and returns all eight registers to a code chosen by a parameter: midscale 0x800, or zero.

Top module: `quad_dac_regs`

## Requirements
- R1: The select code picks the channel: 0 (00) is channel A, 1 is B, 2 is C and 3 is D. Channel k's output code occupies bits [12k+11:12k] of `code`.
- R2: While `cs_n` is high, no staging register changes, whatever `rd_wr`, `sel` or the bus carry. If `ld_n` is also high, no output register changes either.
- R3: A rising edge with `cs_n` low, `rd_wr` low and `ld_n` high stores the bus value in the selected staging register and leaves all four output codes unchanged.
- R4: While `cs_n` is low and `rd_wr` is high, the bus carries the selected staging register in the same cycle, without waiting for a clock edge.
- R5: In every other combination of `cs_n` and `rd_wr`, the block leaves the bus at high impedance.
- R6: A rising edge with `cs_n` high, `ld_n` low and `clr_n` high copies all four staging registers into their output registers at once.
- R7: A rising edge with `cs_n` low, `rd_wr` low and `ld_n` low writes the bus value into both ranks of the selected channel. The other channels' outputs are unchanged.
- R8: A rising edge with `clr_n` low sets every staging and output register to the clear code, whatever `cs_n`, `ld_n` or `rd_wr` carry. Clear takes priority over writes and loads, and the registers stay at the clear code for as long as `clr_n` is held low.
- R9: After reset, every staging and output register holds the clear code and the bus is released.
- R10: A rising edge with `cs_n` low and `rd_wr` high leaves the output codes unchanged, even with `ld_n` low.
- R11: The clear code is 0x800 when `CLR_MID` is 1 (the default) and 0x000 when `CLR_MID` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all controls are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset to the clear code |
| cs_n | input | 1 | Active-low chip select for bus reads and writes |
| rd_wr | input | 1 | 1 = read back the staging register, 0 = write |
| sel | input | 2 | Channel select, 0..3 = A..D |
| ld_n | input | 1 | Active-low load: all-channel transfer, or write-through during a write |
| clr_n | input | 1 | Active-low clear to the clear code, independent of chip select |
| dbus | inout | 12 | Bidirectional data bus, high impedance unless reading |
| code | output | 48 | Four 12-bit output codes, channel A in the low bits |

## Verification
The assertions assume that the host drives `dbus` only during a write cycle (`cs_n` low and `rd_wr` low), so the bus carries a single valid value at each sampled edge. They also assume that every control is steady around the rising edge. The bench changes all controls on the falling edge and enables its own bus driver only when it issues a write. It releases the driver before any read, and checks readback after its inputs have settled within the same low clock phase.

// File: rtl/quad_dac_regs.sv
module quad_dac_regs #(
  parameter int DW      = 12,
  parameter bit CLR_MID = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_wr,
  input  logic [1:0]        sel,
  input  logic              ld_n,
  input  logic              clr_n,
  inout  wire  [DW-1:0]     dbus,
  output logic [4*DW-1:0]   code
);
  localparam int NCH = 4;
  localparam logic [DW-1:0] CLR_CODE = CLR_MID ? (DW'(1) << (DW-1)) : '0;

  logic [NCH-1:0][DW-1:0] inq;
  logic [NCH-1:0][DW-1:0] outq;

  wire wr_en    = !cs_n && !rd_wr;
  wire rd_en    = !cs_n &&  rd_wr;
  wire xfer_all =  cs_n && !ld_n;

  assign dbus = rd_en ? inq[sel] : {DW{1'bz}};
  assign code = outq;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    wire hit = wr_en && (sel == 2'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        inq[g]  <= CLR_CODE;
        outq[g] <= CLR_CODE;
      end else if (!clr_n) begin
        inq[g]  <= CLR_CODE;
        outq[g] <= CLR_CODE;
      end else begin
        if (hit) inq[g] <= dbus;
        if (hit && !ld_n) outq[g] <= dbus;
        else if (xfer_all) outq[g] <= inq[g];
      end
    end
  end
endmodule

// File: rtl/quad_dac_regs_chk.sv
module quad_dac_regs_chk #(
  parameter int DW      = 12,
  parameter bit CLR_MID = 1'b1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cs_n,
  input logic                 rd_wr,
  input logic [1:0]           sel,
  input logic                 ld_n,
  input logic                 clr_n,
  input logic [DW-1:0]        dbus,
  input logic [4*DW-1:0]      code,
  input logic [3:0][DW-1:0]   inq
);
  localparam logic [DW-1:0] CC = CLR_MID ? (DW'(1) << (DW-1)) : '0;
  logic [3:0][DW-1:0] cv;
  assign cv = code;

  // R2
  cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_n && cs_n && ld_n |=> $stable(inq) && $stable(code));
  // R3
  staged_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_n && !cs_n && !rd_wr && ld_n |=> $stable(code));
  // R6
  load_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_n && cs_n && !ld_n |=> code == $past(inq));
  // R7
  write_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_n && !cs_n && !rd_wr && !ld_n |=> cv[$past(sel)] == $past(dbus));
  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> (code == {4{CC}}) && (inq == {4{CC}}));
  // R10
  read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_n && !cs_n && rd_wr |=> $stable(code));
endmodule

bind quad_dac_regs quad_dac_regs_chk #(.DW(DW), .CLR_MID(CLR_MID)) u_chk (.*);

// File: tb/sim_quad_dac_regs.sv
module sim_quad_dac_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, rd_wr = 1'b1, ld_n = 1'b1, clr_n = 1'b1;
  logic [1:0] sel = 2'd0;
  logic [11:0] tb_d = '0;
  logic tb_oe = 1'b0;
  wire  [11:0] dbus, dbus1;
  logic [47:0] code, code1;
  int nchk = 0, nerr = 0;
  logic [11:0] m_in [4];
  logic [11:0] m_out [4];

  always #2 clk = ~clk;

  assign dbus  = tb_oe ? tb_d : 12'hzzz;
  assign dbus1 = tb_oe ? tb_d : 12'hzzz;

  quad_dac_regs u0 (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_wr(rd_wr), .sel(sel),
                    .ld_n(ld_n), .clr_n(clr_n), .dbus(dbus), .code(code));
  quad_dac_regs #(.CLR_MID(1'b0)) u1 (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_wr(rd_wr),
                    .sel(sel), .ld_n(ld_n), .clr_n(clr_n), .dbus(dbus1), .code(code1));

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [47:0] outs();
    return {m_out[3], m_out[2], m_out[1], m_out[0]};
  endfunction

  task automatic idle();
    cs_n = 1'b1; rd_wr = 1'b1; ld_n = 1'b1; clr_n = 1'b1; tb_oe = 1'b0;
  endtask

  task automatic cycle(input logic c, input logic rw, input logic [1:0] s,
                       input logic l, input logic cl, input logic [11:0] d);
    @(negedge clk);
    cs_n = c; rd_wr = rw; sel = s; ld_n = l; clr_n = cl; tb_d = d; tb_oe = !rw;
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic readback(input string req, input logic [1:0] s, input logic [11:0] exp);
    @(negedge clk);
    cs_n = 1'b0; rd_wr = 1'b1; sel = s; tb_oe = 1'b0;
    #1;
    chk(req, {36'd0, dbus}, {36'd0, exp});
    idle();
  endtask

  task automatic t_reset();
    for (int i = 0; i < 4; i++) begin m_in[i] = 12'h800; m_out[i] = 12'h800; end
    @(negedge clk);
    chk("R9 output codes after reset", code, outs());
    chk("R11 zero variant after reset", code1, 48'd0);
    chk("R5 bus released with cs high", {36'd0, dbus}, {36'd0, 12'hzzz});
    rd_wr = 1'b0; #1;
    chk("R5 bus released on write strobe", {36'd0, dbus}, {36'd0, 12'hzzz});
    idle();
    for (int i = 0; i < 4; i++) readback("R9 staging after reset", 2'(i), 12'h800);
  endtask

  task automatic t_staged_write();
    for (int i = 0; i < 4; i++) begin
      m_in[i] = 12'h111 * 12'(i + 1);
      cycle(1'b0, 1'b0, 2'(i), 1'b1, 1'b1, m_in[i]);
      chk("R3 outputs held on staged write", code, outs());
    end
    for (int i = 0; i < 4; i++) readback("R1 R4 readback per channel", 2'(i), m_in[i]);
  endtask

  task automatic t_cs_high();
    cycle(1'b1, 1'b0, 2'd2, 1'b1, 1'b1, 12'hABC);
    chk("R2 outputs unchanged with cs high", code, outs());
    readback("R2 staging unchanged with cs high", 2'd2, m_in[2]);
  endtask

  task automatic t_load_all();
    cycle(1'b1, 1'b1, 2'd0, 1'b0, 1'b1, 12'h000);
    for (int i = 0; i < 4; i++) m_out[i] = m_in[i];
    chk("R6 all channels transferred", code, outs());
  endtask

  task automatic t_write_through();
    cycle(1'b0, 1'b0, 2'd3, 1'b0, 1'b1, 12'hFFF);
    m_in[3] = 12'hFFF; m_out[3] = 12'hFFF;
    chk("R7 R1 write-through to channel D only", code, outs());
    readback("R7 staging follows write-through", 2'd3, 12'hFFF);
    cycle(1'b0, 1'b0, 2'd1, 1'b0, 1'b1, 12'h001);
    m_in[1] = 12'h001; m_out[1] = 12'h001;
    chk("R7 R1 write-through to channel B only", code, outs());
  endtask

  task automatic t_read_load();
    cycle(1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 12'h123);
    m_in[0] = 12'h123;
    cycle(1'b0, 1'b1, 2'd0, 1'b0, 1'b1, 12'h000);
    chk("R10 read with load low holds outputs", code, outs());
    t_load_all();
  endtask

  task automatic t_clear();
    cycle(1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 12'h555);
    for (int i = 0; i < 4; i++) begin m_in[i] = 12'h800; m_out[i] = 12'h800; end
    chk("R8 clear beats write-through", code, outs());
    chk("R11 zero variant clear", code1, 48'd0);
    for (int i = 0; i < 4; i++) readback("R8 staging cleared", 2'(i), 12'h800);
    cycle(1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 12'h3C3);
    @(negedge clk);
    cs_n = 1'b1; ld_n = 1'b0; clr_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 held clear beats load, cs high", code, outs());
    idle();
    readback("R8 staging held at clear code", 2'd0, 12'h800);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    #(4 * 20000);
    nchk++; nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_staged_write();
    t_cs_high();
    t_load_all();
    t_write_through();
    t_read_load();
    t_clear();
    finish_run();
  end
endmodule